// File: doc/BRIEF.md
# Watchdog Timer with Keyed Service Sequence

This block is a watchdog peripheral on a simple 16-bit register bus. Software writes a timeout in half-second units to the control register and sets the enable bit. The block then counts down once for each cycle on which the external half-second tick enable is high. Software keeps the system alive by writing a two-word key to the service register. If it fails to do so, the counter runs out. The block then records a timeout cause and emits a one-clock system-reset pulse.

The control register has several write-once rules. The enable bit and the timeout-assertion bit can only be set, never cleared. The suspend, debug and wait-disable bits take effect only on the first control write after reset. Software can also request a reset directly through control bits 4 and 5. Reset status records the cause of the most recent reset. The interrupt-control register holds its reset value and ignores writes. Only bit 0 of the miscellaneous register is writable. All registers return to their reset values, and all locks are cleared, on the synchronous active-high reset.

Top module: `wdog_svc_top`

## Requirements
- R1: The 16-bit registers are decoded at byte offsets 0x0 (control), 0x2 (service), 0x4 (reset status), 0x6 (interrupt control) and 0x8 (misc). A read of any other 4-bit offset, odd offsets included, returns 0x0000.
- R2: With control timeout field N (bits 15:8) and the enable bit set, the reset pulse follows the (N+1)-th tick after the last reload. Cycles on which the tick input is low do not count. With enable clear, no expiry ever happens.
- R3: Control bit 2 (enable), once written as 1, reads 1 until block reset, whatever is written later.
- R4: Control bit 3 (timeout assertion), once written as 1, reads 1 until block reset.
- R5: Control bits 0, 1 and 7 take the written value only on the first control write after reset. Later control writes leave them unchanged.
- R6: A control write with bit 4 = 0 sets reset status to 0x0001 (software cause). Control bit 4 always reads 1, and bit 6 always reads 0.
- R7: A control write with bits 4 and 5 both 0 drives the reset output high for exactly one clock, in the cycle after the write.
- R8: A service write of 0xAAAA whose preceding service write was 0x5555 reloads the counter with N+1 while enabled. No other order reloads it. The service register reads back the last value written.
- R9: On expiry, reset status becomes 0x0002 (timeout cause) and the reset output pulses for one clock in the cycle after the expiring tick.
- R10: After reset: control 0x0030, service 0x0000, reset status 0x0000, interrupt control 0x0004, misc 0x0001, and reset output low.
- R11: Only misc bit 0 is writable. Writes to reset status and to interrupt control change nothing.
- R12: Every control write that leaves the block enabled reloads the counter with the new N+1 and restarts the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Write strobe, one transfer per cycle |
| bus_addr_i | input | 4 | Byte offset of the access |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i (combinational) |
| tick_en_i | input | 1 | Half-second count enable |
| sys_rst_o | output | 1 | One-clock system-reset pulse |

## Verification
Lock state shows up at the control readback right after the next control write. A wrong lock flag therefore leaves a stale or changed bit visible in the same access pair. An off-by-one in the countdown or a wrong reload shows up as the reset pulse arriving one tick early or late. Because ticks are driven one at a time, that error is visible within a single tick of the expected point. A broken key tracker shows up either as a missed reload, which gives an early pulse, or as a reload after a wrong order, which gives a late pulse or none. The status cause word, read right after each pulse, separates the timeout cause from the software cause.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 4;
    localparam int TMO_W  = 8;
    localparam int CNT_W  = TMO_W + 1;

    typedef enum logic [ADDR_W-1:0] {
        OFF_CTRL = 4'h0,
        OFF_SVC  = 4'h2,
        OFF_STAT = 4'h4,
        OFF_ICTL = 4'h6,
        OFF_MISC = 4'h8
    } reg_off_e;

    typedef struct packed {
        logic [TMO_W-1:0] tmo;
        logic             wait_dis;
        logic             rsv;
        logic             ext_keep;
        logic             sw_keep;
        logic             tout_assert;
        logic             enable;
        logic             dbg;
        logic             suspend;
    } ctrl_t;

    localparam logic [DATA_W-1:0] KEY_ARM  = 16'h5555;
    localparam logic [DATA_W-1:0] KEY_FIRE = 16'hAAAA;
    localparam logic [DATA_W-1:0] CTRL_RST = 16'h0030;
    localparam logic [DATA_W-1:0] ICTL_RST = 16'h0004;
    localparam logic [DATA_W-1:0] MISC_RST = 16'h0001;
    localparam logic [DATA_W-1:0] STAT_SW  = 16'h0001;
    localparam logic [DATA_W-1:0] STAT_TO  = 16'h0002;

    function automatic ctrl_t ctrl_merge(ctrl_t old_v, ctrl_t wr_v, logic first);
        ctrl_t r;
        r             = wr_v;
        r.rsv         = 1'b0;
        r.sw_keep     = 1'b1;
        r.enable      = old_v.enable | wr_v.enable;
        r.tout_assert = old_v.tout_assert | wr_v.tout_assert;
        if (!first) begin
            r.suspend  = old_v.suspend;
            r.dbg      = old_v.dbg;
            r.wait_dis = old_v.wait_dis;
        end
        return r;
    endfunction
endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output ctrl_t             ctrl_o,
    output ctrl_t             ctrl_nxt_o
);
    ctrl_t ctrl_q;
    logic  locked_q;

    always_comb ctrl_nxt_o = ctrl_merge(ctrl_q, ctrl_t'(wdata_i), !locked_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= ctrl_t'(CTRL_RST);
            locked_q <= 1'b0;
        end else if (wr_i) begin
            ctrl_q   <= ctrl_nxt_o;
            locked_q <= 1'b1;
        end
    end

    assign ctrl_o = ctrl_q;

    AST_EN_STICKY: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.enable |=> ctrl_q.enable); // R3
    AST_TOUT_STICKY: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.tout_assert |=> ctrl_q.tout_assert); // R4
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (locked_q && wr_i) |=> $stable({ctrl_q.suspend, ctrl_q.dbg, ctrl_q.wait_dis})); // R5
endmodule

// File: rtl/wdog_service.sv
module wdog_service
    import wdog_pkg::*;
#(
    parameter logic [DATA_W-1:0] ARM  = KEY_ARM,
    parameter logic [DATA_W-1:0] FIRE = KEY_FIRE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] svc_o,
    output logic              reload_o
);
    logic [DATA_W-1:0] svc_q;

    always_ff @(posedge clk) begin
        if (rst)       svc_q <= '0;
        else if (wr_i) svc_q <= wdata_i;
    end

    assign reload_o = wr_i && (svc_q == ARM) && (wdata_i == FIRE);
    assign svc_o    = svc_q;

    AST_RELOAD_FOLLOWS_ARM: assert property (@(posedge clk) disable iff (rst)
        reload_o |=> (svc_q == FIRE)); // R8
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             load_en_i,
    input  logic [TMO_W-1:0] tmo_i,
    input  logic             run_i,
    input  logic             tick_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             step;

    assign step     = run_i && tick_i && !load_i && (cnt_q != '0);
    assign expire_o = step && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst)                    cnt_q <= '0;
        else if (load_i && load_en_i) cnt_q <= CNT_W'(tmo_i) + CNT_W'(1);
        else if (step)              cnt_q <= cnt_q - CNT_W'(1);
    end

    AST_EXPIRE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        expire_o |=> (cnt_q == '0)); // R2
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !load_i) |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/wdog_svc_top.sv
module wdog_svc_top
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              tick_en_i,
    output logic              sys_rst_o
);
    ctrl_t             ctrl_q, ctrl_nxt;
    logic [DATA_W-1:0] svc_q, stat_q;
    logic              misc_q, rst_q;
    logic              wr_ctrl, wr_svc, wr_misc, svc_reload, expire;
    logic              cnt_load, cnt_load_en, sw_req, ext_req;
    logic [TMO_W-1:0]  cnt_tmo;

    assign wr_ctrl = bus_wr_i && (bus_addr_i == OFF_CTRL);
    assign wr_svc  = bus_wr_i && (bus_addr_i == OFF_SVC);
    assign wr_misc = bus_wr_i && (bus_addr_i == OFF_MISC);
    assign sw_req  = wr_ctrl && !bus_wdata_i[4];
    assign ext_req = sw_req && !bus_wdata_i[5];

    wdog_ctrl_reg u_ctrl (
        .clk(clk), .rst(rst), .wr_i(wr_ctrl), .wdata_i(bus_wdata_i),
        .ctrl_o(ctrl_q), .ctrl_nxt_o(ctrl_nxt)
    );

    wdog_service u_svc (
        .clk(clk), .rst(rst), .wr_i(wr_svc), .wdata_i(bus_wdata_i),
        .svc_o(svc_q), .reload_o(svc_reload)
    );

    assign cnt_load    = wr_ctrl || svc_reload;
    assign cnt_load_en = wr_ctrl ? ctrl_nxt.enable : ctrl_q.enable;
    assign cnt_tmo     = wr_ctrl ? ctrl_nxt.tmo : ctrl_q.tmo;

    wdog_counter u_cnt (
        .clk(clk), .rst(rst), .load_i(cnt_load), .load_en_i(cnt_load_en),
        .tmo_i(cnt_tmo), .run_i(ctrl_q.enable), .tick_i(tick_en_i),
        .expire_o(expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            misc_q <= MISC_RST[0];
            rst_q  <= 1'b0;
        end else begin
            if (expire)      stat_q <= STAT_TO;
            else if (sw_req) stat_q <= STAT_SW;
            if (wr_misc)     misc_q <= bus_wdata_i[0];
            rst_q <= expire || ext_req;
        end
    end

    always_comb begin
        case (bus_addr_i)
            OFF_CTRL: bus_rdata_o = ctrl_q;
            OFF_SVC:  bus_rdata_o = svc_q;
            OFF_STAT: bus_rdata_o = stat_q;
            OFF_ICTL: bus_rdata_o = ICTL_RST;
            OFF_MISC: bus_rdata_o = {{(DATA_W-1){1'b0}}, misc_q};
            default:  bus_rdata_o = '0;
        endcase
    end

    assign sys_rst_o = rst_q;

    AST_RST_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        sys_rst_o |-> (stat_q == STAT_TO || stat_q == STAT_SW)); // R9
    AST_STAT_ONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stat_q)); // R6
    AST_EXPIRE_PULSE: assert property (@(posedge clk) disable iff (rst)
        expire |=> sys_rst_o); // R9
endmodule

// File: tb/tb_wdog_svc_top.sv
module tb_wdog_svc_top;
    logic        clk = 1'b0;
    logic        rst, wr, tick;
    logic [3:0]  addr;
    logic [15:0] wdata, rdata;
    logic        srst;
    int          n_chk = 0, n_bad = 0;
    logic        seen, done = 1'b0;
    // bench model
    logic [15:0] m_ctrl, m_svc, m_stat;
    logic        m_misc, m_first;

    always #5 clk = ~clk;

    wdog_svc_top dut (
        .clk(clk), .rst(rst), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tick_en_i(tick), .sys_rst_o(srst)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ctrl_model(logic [15:0] o, logic [15:0] v, logic first);
        logic [15:0] r;
        r = v; r[6] = 1'b0; r[4] = 1'b1;
        r[2] = o[2] | v[2]; r[3] = o[3] | v[3];
        if (!first) begin r[0] = o[0]; r[1] = o[1]; r[7] = o[7]; end
        return r;
    endfunction

    function automatic logic [15:0] read_model(logic [3:0] a);
        case (a)
            4'h0: return m_ctrl;
            4'h2: return m_svc;
            4'h4: return m_stat;
            4'h6: return 16'h0004;
            4'h8: return {15'd0, m_misc};
            default: return 16'h0000;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1; wr = 0; tick = 0; addr = 0; wdata = 0;
        @(negedge clk); @(negedge clk); rst = 0;
        m_ctrl = 16'h0030; m_svc = 0; m_stat = 0; m_misc = 1; m_first = 1;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); wr = 1; addr = a; wdata = d;
        @(negedge clk); wr = 0; seen = srst;
        case (a)
            4'h0: begin
                m_ctrl = ctrl_model(m_ctrl, d, m_first); m_first = 0;
                if (!d[4]) m_stat = 16'h0001;
            end
            4'h2: m_svc = d;
            4'h8: m_misc = d[0];
            default: ;
        endcase
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk); addr = a; #1 v = rdata;
    endtask

    task automatic one_tick();
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 0; seen = srst;
    endtask

    // counts pulses over k ticks
    task automatic ticks(input int k, output int pulses);
        pulses = 0;
        for (int i = 0; i < k; i++) begin one_tick(); if (seen) pulses++; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int p;
        void'($urandom(32'd1234));
        rst = 1; wr = 0; tick = 0; addr = 0; wdata = 0;
        do_reset();
        // R10 reset values
        for (int a = 0; a < 16; a++) begin
            rd_reg(4'(a), v); check("R10 reset value", v, read_model(4'(a)));
        end
        check("R10 reset output low", {15'd0, srst}, 16'd0);

        // R2 R9: N=3, pulse on 4th tick
        wr_reg(4'h0, 16'h0334);
        ticks(3, p); check("R2 no early expiry", 16'(p), 16'd0);
        one_tick(); check("R9 expiry pulse", {15'd0, seen}, 16'd1);
        @(negedge clk); check("R9 pulse one cycle", {15'd0, srst}, 16'd0);
        rd_reg(4'h4, v); check("R9 timeout cause", v, 16'h0002);
        // R2 tick gating: idle cycles without tick
        repeat (20) @(negedge clk);
        check("R2 counter stopped", {15'd0, srst}, 16'd0);

        // R2 N=0 -> single tick
        do_reset(); wr_reg(4'h0, 16'h0034);
        one_tick(); check("R2 N=0 one tick", {15'd0, seen}, 16'd1);

        // R2 not enabled: never expires
        do_reset(); wr_reg(4'h0, 16'h0030);
        ticks(10, p); check("R2 disabled no expiry", 16'(p), 16'd0);

        // R8 correct service sequence reloads
        do_reset(); wr_reg(4'h0, 16'h0234);
        ticks(2, p);
        wr_reg(4'h2, 16'h5555); wr_reg(4'h2, 16'hAAAA);
        ticks(2, p); check("R8 reload delays expiry", 16'(p), 16'd0);
        one_tick(); check("R8 expiry after reload", {15'd0, seen}, 16'd1);
        rd_reg(4'h2, v); check("R8 service readback", v, 16'hAAAA);

        // R8 wrong orders do not reload
        do_reset(); wr_reg(4'h0, 16'h0234);
        ticks(2, p);
        wr_reg(4'h2, 16'hAAAA); wr_reg(4'h2, 16'h5555);
        wr_reg(4'h2, 16'h1234); wr_reg(4'h2, 16'hAAAA);
        one_tick(); check("R8 wrong order no reload", {15'd0, seen}, 16'd1);

        // R12 control write reloads
        do_reset(); wr_reg(4'h0, 16'h0134);
        ticks(1, p);
        wr_reg(4'h0, 16'h0134);
        ticks(1, p); check("R12 restart on ctrl write", 16'(p), 16'd0);
        one_tick(); check("R12 expiry after restart", {15'd0, seen}, 16'd1);

        // R7 R6 software reset request
        do_reset(); wr_reg(4'h0, 16'h0000);
        check("R7 ext reset pulse", {15'd0, seen}, 16'd1);
        @(negedge clk); check("R7 pulse width", {15'd0, srst}, 16'd0);
        rd_reg(4'h4, v); check("R6 software cause", v, 16'h0001);
        wr_reg(4'h0, 16'h0020);
        check("R7 bit5 set no pulse", {15'd0, seen}, 16'd0);

        // R3 R4 R5 directed
        do_reset(); wr_reg(4'h0, 16'h00BF);
        wr_reg(4'h0, 16'h0030);
        rd_reg(4'h0, v); check("R3 R4 R5 sticky and locked", v, 16'h00BF);

        // R11 directed
        wr_reg(4'h4, 16'hFFFF); wr_reg(4'h6, 16'hFFFF); wr_reg(4'h8, 16'hFFFE);
        rd_reg(4'h4, v); check("R11 status write ignored", v, m_stat);
        rd_reg(4'h6, v); check("R11 ictl write ignored", v, 16'h0004);
        rd_reg(4'h8, v); check("R11 misc bit0 only", v, 16'h0000);

        // R1 R3 R4 R5 R6 R7 R11 random register traffic, ticks held low
        do_reset();
        for (int i = 0; i < 300; i++) begin
            logic [3:0]  a;
            logic [15:0] d;
            a = 4'($urandom_range(0, 15));
            d = 16'($urandom);
            if ($urandom_range(0, 3) == 0) d = ($urandom_range(0, 1) == 1) ? 16'h5555 : 16'hAAAA;
            if ($urandom_range(0, 7) == 0) do_reset();
            wr_reg(a, d);
            check("R7 pulse on write", {15'd0, seen},
                  {15'd0, (a == 4'h0) && !d[4] && !d[5]});
            a = 4'($urandom_range(0, 15));
            rd_reg(a, v); check("R1 readback", v, read_model(a));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule